// File: doc/BRIEF.md
# Row-Bypassing Unsigned Array Multiplier

This block multiplies two unsigned M-bit operands and returns the full 2M-bit product in a single combinational pass. It is an array of ripple-carry adder rows: the first row forms the partial product for the low bit of the second operand (the multiplicator). Each later row adds the next shifted partial product to the running sum that comes down from the row above.

Every adder row after the first belongs to one multiplicator bit. When that bit is zero, the row contributes nothing. Its full adders then have their inputs forced to zero, so they stay idle. A row of muxes passes the running sum from the row above straight through, with a zero carry out. When the bit is one, the row's own sums and carry are selected. The last row's ripple chain resolves the upper product bits. Whatever the pattern of bypassed rows, the product must be exact. The block is meant for use where many multiplicator bits are zero and idle adder rows save switching activity.

Top module: `rowbyp_mult`

## Requirements
- R1: `product` equals the unsigned product of `a` and `b`, for every operand pair, at any width parameter M of 2 or more (default M = 4).
- R2: When `b` is zero, every adder row is bypassed and `product` is zero.
- R3: When `b` equals 1, only the first row contributes and `product` equals `a` zero-extended to 2M bits.
- R4: When `b` has exactly one bit set, at position k, `product` equals `a` shifted left by k.
- R5: When `a` is zero, `product` is zero for any `b`.
- R6: With `a` = 4'b1111 and `b` = 4'b1001 at M = 4, the two middle rows are bypassed and `product` is 8'd135.
- R7: With both operands at their maximum value 2^M-1, `product` is (2^M-1)^2. For M = 4 that is 8'd225, with the top carry out of the last row set.
- R8: Bit 0 of `product` equals the AND of bit 0 of `a` and bit 0 of `b`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | M | Multiplicand, unsigned |
| b | input | M | Multiplicator, unsigned; bit j selects or bypasses adder row j |
| product | output | 2M | Unsigned product a*b |

## Verification
A wrong bypass decision or a lost carry in any row shows up at once at `product`, because the block holds no state. The error appears in the same evaluation as the operand change. A row that is bypassed when it should be active drops a shifted copy of `a`. A row that keeps a stale carry adds a stray power of two. Both are caught by exact comparison against a*b. The checks therefore sweep every operand pair at M = 4, so each bypass pattern is exercised. At M = 16 they use random and single-bit multiplicators, which reach the long carry chains.

// File: rtl/rowbyp_mult.sv
module rowbyp_mult #(
  parameter int M = 4
) (
  input  logic [M-1:0]   a,
  input  logic [M-1:0]   b,
  output logic [2*M-1:0] product
);

  localparam int PW = 2 * M;

  logic [M-1:0] acc [M];
  logic [M-1:0] cout;

  assign acc[0]  = a & {M{b[0]}};
  assign cout[0] = 1'b0;

  for (genvar j = 1; j < M; j++) begin : g_row
    logic [M-1:0] up;
    logic [M-1:0] fa_u;
    logic [M-1:0] fa_p;
    logic [M-1:0] fa_s;
    logic [M:0]   ch;

    assign up    = {cout[j-1], acc[j-1][M-1:1]};
    assign fa_u  = up & {M{b[j]}};
    assign fa_p  = a  & {M{b[j]}};
    assign ch[0] = 1'b0;

    for (genvar i = 0; i < M; i++) begin : g_fa
      assign fa_s[i]  = fa_u[i] ^ fa_p[i] ^ ch[i];
      assign ch[i+1]  = (fa_u[i] & fa_p[i]) | (ch[i] & (fa_u[i] ^ fa_p[i]));
    end

    assign acc[j]  = b[j] ? fa_s  : up;
    assign cout[j] = b[j] ? ch[M] : 1'b0;
  end

  for (genvar k = 0; k < M - 1; k++) begin : g_lo
    assign product[k] = acc[k][0];
  end
  assign product[PW-1:M-1] = {cout[M-1], acc[M-1]};

  always_comb begin
    if (!$isunknown({a, b, product})) begin
      a_r1_exact_product: assert (product == ({{M{1'b0}}, a} * {{M{1'b0}}, b}));
      if (b == '0) begin
        a_r2_all_bypassed: assert (product == '0);
      end
      if (b == M'(1)) begin
        a_r3_unit_multiplicator: assert (product == {{M{1'b0}}, a});
      end
      if (a == '0) begin
        a_r5_zero_multiplicand: assert (product == '0);
      end
      a_r8_lsb: assert (product[0] == (a[0] & b[0]));
    end
  end

endmodule

// File: tb/rowbyp_mult_tb.sv
`timescale 1ns/1ps
module rowbyp_mult_tb;

  localparam int MS = 4;
  localparam int ML = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [MS-1:0]   a4, b4;
  logic [2*MS-1:0] p4;
  logic [ML-1:0]   a16, b16;
  logic [2*ML-1:0] p16;

  rowbyp_mult #(.M(MS)) u_dut   (.a(a4),  .b(b4),  .product(p4));
  rowbyp_mult #(.M(ML)) u_dut16 (.a(a16), .b(b16), .product(p16));

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [2*ML-1:0] exp_q [$];
  string           tag_q [$];
  bit              wide_q [$];

  task automatic drive4(input logic [MS-1:0] x, input logic [MS-1:0] y, input string tag);
    @(posedge clk);
    #1;
    a4 = x; b4 = y;
    exp_q.push_back((2*ML)'({{MS{1'b0}}, x} * {{MS{1'b0}}, y}));
    tag_q.push_back(tag);
    wide_q.push_back(1'b0);
  endtask

  task automatic drive16(input logic [ML-1:0] x, input logic [ML-1:0] y, input string tag);
    @(posedge clk);
    #1;
    a16 = x; b16 = y;
    exp_q.push_back({{ML{1'b0}}, x} * {{ML{1'b0}}, y});
    tag_q.push_back(tag);
    wide_q.push_back(1'b1);
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [2*ML-1:0] e, got;
      string t;
      bit w;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      w = wide_q.pop_front();
      got = w ? p16 : (2*ML)'(p4);
      n_chk++;
      if (got !== e) begin
        n_fail++;
        $display("FAIL %s: a=%0h b=%0h got %0h expected %0h",
                 t, w ? a16 : (ML)'(a4), w ? b16 : (ML)'(b4), got, e);
      end
    end
  end

  initial begin
    a4 = '0; b4 = '0; a16 = '0; b16 = '0;
    drive4(4'h0, 4'h0, "R2 reset-state zero");
    drive4(4'hF, 4'h9, "R6 rows 1,2 bypassed");
    drive4(4'hF, 4'hF, "R7 max operands");
    drive4(4'hB, 4'h0, "R2 b zero");
    drive4(4'hB, 4'h1, "R3 b one");
    drive4(4'h0, 4'hD, "R5 a zero");
    for (int k = 0; k < MS; k++) drive4(4'h7, 4'(1 << k), "R4 single row");
    for (int x = 0; x < 16; x++)
      for (int y = 0; y < 16; y++)
        drive4(4'(x), 4'(y), "R1 exhaustive 4x4 (R8 lsb)");
    drive16('1, '1, "R7 max 16x16");
    drive16(16'hBEEF, 16'h0, "R2 b zero 16");
    drive16(16'hBEEF, 16'h1, "R3 b one 16");
    drive16(16'h0, 16'hFFFF, "R5 a zero 16");
    for (int k = 0; k < ML; k++) drive16(16'hA5C3, 16'(1 << k), "R4 single row 16");
    for (int n = 0; n < 2000; n++)
      drive16(16'($urandom), 16'($urandom), "R1 random 16x16");
    for (int n = 0; n < 200; n++)
      drive16(16'($urandom), 16'($urandom) & 16'($urandom), "R1 sparse b 16x16");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule